// File: doc/BRIEF.md
# Doorbell and Message Interrupt Unit

This block is a small register file that lets a host bus master and a local processor signal each other. Each side has its own simple register port, with an address, a write strobe and data, and a read strobe with registered read data. Each side writes a pair of 32-bit message registers and a doorbell register that the other side reads. Every such write raises a sticky status bit on the receiving side. When that bit is enabled in the receiver's mask, the receiver's interrupt line asserts.

There are two status registers. The inbound one is read by the local side and the outbound one by the host side. A status read returns status ANDed with the mask and then clears the status. A doorbell read returns the doorbell contents and clears them. Bit 31 of the inbound doorbell is reserved for machine check and drives a status bit of its own. Four event inputs from external message queues also set sticky status bits. The queues themselves are outside this block.

Top module: `msg_irq_unit`

## Requirements
- R1: After reset, all message, doorbell, status and mask registers read 0, both interrupt outputs are low and both read data outputs are 0.
- R2: A host write to 0x50 or 0x54 loads inbound message 0 or 1, which the local side reads at the same offsets, and sets inbound status bit 0 or 1. A local write to 0x58 or 0x5C loads outbound message 0 or 1, which the host reads there, and sets outbound status bit 0 or 1.
- R3: A write to an offset that belongs to the other side has no effect on any register or status bit.
- R4: A doorbell write ORs its data into the doorbell register. The local side writes the outbound doorbell at 0x60 and the host reads it there. The host writes the inbound doorbell at 0x68 and the local side reads it there. A doorbell read returns the contents and clears the register.
- R5: A doorbell write whose result is nonzero in the non-machine-check bits sets status bit 3 on the receiving side. On the inbound doorbell, writing bit 31 set sets inbound status bit 4 (machine check), independently of bit 3.
- R6: The mask is at 0x34 (host side, outbound) and 0x104 (local side, inbound), is read/write, and a 1 enables a source. Reading status at 0x30 (host) or 0x100 (local) returns status AND mask, and the read clears every status bit.
- R7: Each interrupt output is a register equal to the OR of the enabled, set status bits. It is updated on the same clock edge that changes the status or the mask.
- R8: While asserted at a clock edge, the inputs for inbound post-queue not empty, inbound post-queue overflow and outbound free-queue overflow set inbound status bits 5, 7 and 8. The input for outbound post-queue not empty sets outbound status bit 5.
- R9: An event in the same cycle as a clearing read of the same status or doorbell register wins. The read returns the old value, and the new bit or data remains afterwards.
- R10: Read data appears on the clock edge that samples the read strobe and holds until the next read. An offset that the reading side cannot read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 12 | Host-side register offset |
| host_we_i | input | 1 | Host write strobe |
| host_wdata_i | input | 32 | Host write data |
| host_re_i | input | 1 | Host read strobe |
| host_rdata_o | output | 32 | Host read data, registered |
| loc_addr_i | input | 12 | Local-side register offset |
| loc_we_i | input | 1 | Local write strobe |
| loc_wdata_i | input | 32 | Local write data |
| loc_re_i | input | 1 | Local read strobe |
| loc_rdata_o | output | 32 | Local read data, registered |
| ib_postq_nempty_i | input | 1 | Inbound post queue holds entries |
| ib_postq_ovf_i | input | 1 | Inbound post queue overflowed |
| ob_freeq_ovf_i | input | 1 | Outbound free queue overflowed |
| ob_postq_nempty_i | input | 1 | Outbound post queue holds entries |
| host_irq_o | output | 1 | Interrupt to the host |
| loc_irq_o | output | 1 | Interrupt to the local processor |

## Verification
The assertions assume that a strobe is sampled only on a rising edge and that each port's address is stable whenever its strobe is high. The stickiness check assumes that only a clearing read of the inbound status lowers any of its bits. The bench drives every strobe and address on the falling edge and holds it for exactly one cycle. It raises the queue event inputs only for one-cycle pulses. It creates the same-cycle collisions of R9 on purpose, with one port reading while the other writes.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
  localparam int unsigned IB_MSG_BASE = 'h050;
  localparam int unsigned OB_MSG_BASE = 'h058;
  localparam int unsigned OB_DB_OFF   = 'h060;
  localparam int unsigned IB_DB_OFF   = 'h068;
  localparam int unsigned OB_STAT_OFF = 'h030;
  localparam int unsigned OB_MASK_OFF = 'h034;
  localparam int unsigned IB_STAT_OFF = 'h100;
  localparam int unsigned IB_MASK_OFF = 'h104;
  localparam int unsigned MSG_STRIDE  = 4;
  localparam int unsigned MC_BIT      = 31;

  // status bit positions
  localparam int unsigned ST_MSG0   = 0;
  localparam int unsigned ST_MSG1   = 1;
  localparam int unsigned ST_DB     = 3;
  localparam int unsigned ST_MC     = 4;
  localparam int unsigned ST_PQ_NE  = 5;
  localparam int unsigned ST_PQ_OVF = 7;
  localparam int unsigned ST_FQ_OVF = 8;
  localparam int unsigned STAT_W    = 9;
endpackage

// File: rtl/msg_irq_mbox.sv
module msg_irq_mbox #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NMSG = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NMSG-1:0]          we_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NMSG-1:0][DW-1:0]  q_o
);
  for (genvar i = 0; i < NMSG; i++) begin : g_msg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_o[i] <= '0;
      else if (we_i[i]) q_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/msg_irq_dbell.sv
module msg_irq_dbell #(
  parameter int unsigned DW      = 32,
  parameter bit          HAS_SPC = 1'b0,
  parameter int unsigned SPC_BIT = 31
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_i,
  output logic [DW-1:0] q_o,
  output logic          db_evt_o,
  output logic          spc_evt_o
);
  logic [DW-1:0] spc_mask;
  logic [DW-1:0] db_d;

  if (HAS_SPC) begin : g_spc
    assign spc_mask = DW'(1) << SPC_BIT;
  end else begin : g_nospc
    assign spc_mask = '0;
  end

  // clear first, then merge the write: a colliding write survives
  assign db_d      = (clr_i ? '0 : q_o) | (we_i ? wdata_i : '0);
  assign db_evt_o  = we_i && |(db_d & ~spc_mask);
  assign spc_evt_o = we_i && |(wdata_i & spc_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= db_d;
  end
endmodule

// File: rtl/msg_irq_stat.sv
module msg_irq_stat #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         rd_clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] stat_d, mask_d;

  assign stat_d = (rd_clr_i ? '0 : stat_o) | set_i;
  assign mask_d = mask_we_i ? mask_wdata_i : mask_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
      mask_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_o <= stat_d;
      mask_o <= mask_d;
      irq_o  <= |(stat_d & mask_d);
    end
  end
endmodule

// File: rtl/msg_irq_unit.sv
module msg_irq_unit #(
  parameter int unsigned AW   = 12,
  parameter int unsigned DW   = 32,
  parameter int unsigned NMSG = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] host_addr_i,
  input  logic          host_we_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_re_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic [AW-1:0] loc_addr_i,
  input  logic          loc_we_i,
  input  logic [DW-1:0] loc_wdata_i,
  input  logic          loc_re_i,
  output logic [DW-1:0] loc_rdata_o,
  input  logic          ib_postq_nempty_i,
  input  logic          ib_postq_ovf_i,
  input  logic          ob_freeq_ovf_i,
  input  logic          ob_postq_nempty_i,
  output logic          host_irq_o,
  output logic          loc_irq_o
);
  import msg_irq_pkg::*;

  localparam int unsigned SW = STAT_W;

  logic [NMSG-1:0]         ib_msg_we, ob_msg_we;
  logic [NMSG-1:0][DW-1:0] ib_msg, ob_msg;
  logic [DW-1:0]           ib_db, ob_db;
  logic                    ib_db_we, ob_db_we, ib_db_clr, ob_db_clr;
  logic                    ib_db_evt, ob_db_evt, ib_mc_evt, ob_spc_unused;
  logic [SW-1:0]           ib_set, ob_set, ib_stat, ob_stat, ib_mask, ob_mask;
  logic                    ib_stat_rd, ob_stat_rd, ib_mask_we, ob_mask_we;
  logic [DW-1:0]           host_rd_d, loc_rd_d;

  function automatic logic hit(input logic [AW-1:0] a, input int unsigned off);
    return a == AW'(off);
  endfunction

  // write decode: host owns inbound writes, local owns outbound writes
  for (genvar i = 0; i < NMSG; i++) begin : g_dec
    assign ib_msg_we[i] = host_we_i && hit(host_addr_i, IB_MSG_BASE + MSG_STRIDE*i);
    assign ob_msg_we[i] = loc_we_i  && hit(loc_addr_i,  OB_MSG_BASE + MSG_STRIDE*i);
  end

  assign ib_db_we   = host_we_i && hit(host_addr_i, IB_DB_OFF);
  assign ob_db_we   = loc_we_i  && hit(loc_addr_i,  OB_DB_OFF);
  assign ib_db_clr  = loc_re_i  && hit(loc_addr_i,  IB_DB_OFF);
  assign ob_db_clr  = host_re_i && hit(host_addr_i, OB_DB_OFF);
  assign ib_stat_rd = loc_re_i  && hit(loc_addr_i,  IB_STAT_OFF);
  assign ob_stat_rd = host_re_i && hit(host_addr_i, OB_STAT_OFF);
  assign ib_mask_we = loc_we_i  && hit(loc_addr_i,  IB_MASK_OFF);
  assign ob_mask_we = host_we_i && hit(host_addr_i, OB_MASK_OFF);

  msg_irq_mbox #(.DW(DW), .NMSG(NMSG)) i_ib_mbox (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ib_msg_we), .wdata_i(host_wdata_i), .q_o(ib_msg));
  msg_irq_mbox #(.DW(DW), .NMSG(NMSG)) i_ob_mbox (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ob_msg_we), .wdata_i(loc_wdata_i), .q_o(ob_msg));

  msg_irq_dbell #(.DW(DW), .HAS_SPC(1'b1), .SPC_BIT(MC_BIT)) i_ib_db (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ib_db_we), .wdata_i(host_wdata_i),
    .clr_i(ib_db_clr), .q_o(ib_db), .db_evt_o(ib_db_evt), .spc_evt_o(ib_mc_evt));
  msg_irq_dbell #(.DW(DW), .HAS_SPC(1'b0), .SPC_BIT(MC_BIT)) i_ob_db (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ob_db_we), .wdata_i(loc_wdata_i),
    .clr_i(ob_db_clr), .q_o(ob_db), .db_evt_o(ob_db_evt), .spc_evt_o(ob_spc_unused));

  always_comb begin
    ib_set = '0;
    ob_set = '0;
    ib_set[ST_MSG0]   = ib_msg_we[0];
    ib_set[ST_MSG1]   = ib_msg_we[1];
    ib_set[ST_DB]     = ib_db_evt;
    ib_set[ST_MC]     = ib_mc_evt;
    ib_set[ST_PQ_NE]  = ib_postq_nempty_i;
    ib_set[ST_PQ_OVF] = ib_postq_ovf_i;
    ib_set[ST_FQ_OVF] = ob_freeq_ovf_i;
    ob_set[ST_MSG0]   = ob_msg_we[0];
    ob_set[ST_MSG1]   = ob_msg_we[1];
    ob_set[ST_DB]     = ob_db_evt;
    ob_set[ST_PQ_NE]  = ob_postq_nempty_i;
  end

  msg_irq_stat #(.W(SW)) i_ib_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ib_set), .rd_clr_i(ib_stat_rd),
    .mask_we_i(ib_mask_we), .mask_wdata_i(loc_wdata_i[SW-1:0]),
    .stat_o(ib_stat), .mask_o(ib_mask), .irq_o(loc_irq_o));
  msg_irq_stat #(.W(SW)) i_ob_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ob_set), .rd_clr_i(ob_stat_rd),
    .mask_we_i(ob_mask_we), .mask_wdata_i(host_wdata_i[SW-1:0]),
    .stat_o(ob_stat), .mask_o(ob_mask), .irq_o(host_irq_o));

  // read muxes
  always_comb begin
    host_rd_d = '0;
    for (int i = 0; i < NMSG; i++)
      if (hit(host_addr_i, OB_MSG_BASE + MSG_STRIDE*i)) host_rd_d = ob_msg[i];
    if (hit(host_addr_i, OB_DB_OFF))   host_rd_d = ob_db;
    if (hit(host_addr_i, OB_STAT_OFF)) host_rd_d = {{(DW-SW){1'b0}}, ob_stat & ob_mask};
    if (hit(host_addr_i, OB_MASK_OFF)) host_rd_d = {{(DW-SW){1'b0}}, ob_mask};
  end

  always_comb begin
    loc_rd_d = '0;
    for (int i = 0; i < NMSG; i++)
      if (hit(loc_addr_i, IB_MSG_BASE + MSG_STRIDE*i)) loc_rd_d = ib_msg[i];
    if (hit(loc_addr_i, IB_DB_OFF))   loc_rd_d = ib_db;
    if (hit(loc_addr_i, IB_STAT_OFF)) loc_rd_d = {{(DW-SW){1'b0}}, ib_stat & ib_mask};
    if (hit(loc_addr_i, IB_MASK_OFF)) loc_rd_d = {{(DW-SW){1'b0}}, ib_mask};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_rdata_o <= '0;
      loc_rdata_o  <= '0;
    end else begin
      if (host_re_i) host_rdata_o <= host_rd_d;
      if (loc_re_i)  loc_rdata_o  <= loc_rd_d;
    end
  end
endmodule

// File: rtl/msg_irq_chk.sv
module msg_irq_chk #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] host_addr_i,
  input logic          host_we_i,
  input logic [DW-1:0] host_wdata_i,
  input logic [AW-1:0] loc_addr_i,
  input logic          loc_we_i,
  input logic          loc_re_i,
  input logic          host_irq_o,
  input logic          loc_irq_o,
  input logic [SW-1:0] ib_stat,
  input logic [SW-1:0] ib_mask,
  input logic [SW-1:0] ob_stat,
  input logic [SW-1:0] ob_mask,
  input logic [DW-1:0] ib_db,
  input logic [DW-1:0] ib_msg0,
  input logic [DW-1:0] ob_msg0
);
  import msg_irq_pkg::*;

  AST_LOC_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_irq_o == |(ib_stat & ib_mask));  // R7
  AST_HOST_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o == |(ob_stat & ob_mask));  // R7
  AST_MSG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_addr_i == AW'(IB_MSG_BASE)) |=> ib_msg0 == $past(host_wdata_i));  // R2
  AST_FOREIGN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_addr_i == AW'(OB_MSG_BASE) && !loc_we_i) |=> $stable(ob_msg0));  // R3
  AST_DB_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_re_i && loc_addr_i == AW'(IB_DB_OFF) && !(host_we_i && host_addr_i == AW'(IB_DB_OFF)))
    |=> ib_db == '0);  // R4
  AST_MC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_addr_i == AW'(IB_DB_OFF) && host_wdata_i[MC_BIT]) |=> ib_stat[ST_MC]);  // R5
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(loc_re_i && loc_addr_i == AW'(IB_STAT_OFF)) |=> ((ib_stat & $past(ib_stat)) == $past(ib_stat)));  // R6
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_addr_i == AW'(IB_MSG_BASE)) |=> ib_stat[ST_MSG0]);  // R9
endmodule

bind msg_irq_unit msg_irq_chk #(.AW(AW), .DW(DW), .SW(msg_irq_pkg::STAT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_addr_i(host_addr_i), .host_we_i(host_we_i),
  .host_wdata_i(host_wdata_i), .loc_addr_i(loc_addr_i), .loc_we_i(loc_we_i),
  .loc_re_i(loc_re_i), .host_irq_o(host_irq_o), .loc_irq_o(loc_irq_o),
  .ib_stat(ib_stat), .ib_mask(ib_mask), .ob_stat(ob_stat), .ob_mask(ob_mask),
  .ib_db(ib_db), .ib_msg0(ib_msg[0]), .ob_msg0(ob_msg[0]));

// File: tb/test_msg_irq_unit.sv
module test_msg_irq_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] host_addr_i = '0, loc_addr_i = '0;
  logic        host_we_i = 1'b0, host_re_i = 1'b0, loc_we_i = 1'b0, loc_re_i = 1'b0;
  logic [31:0] host_wdata_i = '0, loc_wdata_i = '0;
  logic [31:0] host_rdata_o, loc_rdata_o;
  logic        ib_postq_nempty_i = 1'b0, ib_postq_ovf_i = 1'b0;
  logic        ob_freeq_ovf_i = 1'b0, ob_postq_nempty_i = 1'b0;
  logic        host_irq_o, loc_irq_o;
  int          checks = 0, failures = 0;

  always #5 clk_i = ~clk_i;

  msg_irq_unit i_msg_irq_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic h_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i); host_addr_i = a; host_wdata_i = d; host_we_i = 1'b1;
    @(negedge clk_i); host_we_i = 1'b0;
  endtask
  task automatic l_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i); loc_addr_i = a; loc_wdata_i = d; loc_we_i = 1'b1;
    @(negedge clk_i); loc_we_i = 1'b0;
  endtask
  task automatic h_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i); host_addr_i = a; host_re_i = 1'b1;
    @(negedge clk_i); host_re_i = 1'b0; d = host_rdata_o;
  endtask
  task automatic l_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i); loc_addr_i = a; loc_re_i = 1'b1;
    @(negedge clk_i); loc_re_i = 1'b0; d = loc_rdata_o;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 host_rdata", host_rdata_o, 0);
    chk("R1 loc_rdata", loc_rdata_o, 0);
    chk("R1 irqs", {host_irq_o, loc_irq_o}, 0);
    h_rd(12'h058, d); chk("R1 ob msg0", d, 0);
    l_rd(12'h104, d); chk("R1 ib mask", d, 0);
    l_rd(12'h068, d); chk("R1 ib doorbell", d, 0);
  endtask

  task automatic t_msg;
    logic [31:0] d;
    l_wr(12'h104, 32'h1FF);
    h_wr(12'h050, 32'hA5A5_0001);
    h_wr(12'h054, 32'h0000_BEEF);
    chk("R7 loc irq up", loc_irq_o, 1);
    l_rd(12'h050, d); chk("R2 ib msg0", d, 32'hA5A5_0001);
    l_rd(12'h054, d); chk("R2 ib msg1", d, 32'h0000_BEEF);
    l_rd(12'h100, d); chk("R2 ib status", d, 32'h3);
    chk("R7 loc irq down", loc_irq_o, 0);
    l_rd(12'h100, d); chk("R6 cleared", d, 0);
    l_wr(12'h058, 32'h1234);
    l_wr(12'h05C, 32'h5678);
    chk("R6 masked irq", host_irq_o, 0);
    h_wr(12'h034, 32'h2B);
    chk("R7 host irq on mask", host_irq_o, 1);
    h_rd(12'h034, d); chk("R6 ob mask", d, 32'h2B);
    h_rd(12'h058, d); chk("R2 ob msg0", d, 32'h1234);
    h_rd(12'h05C, d); chk("R2 ob msg1", d, 32'h5678);
    h_rd(12'h030, d); chk("R2 ob status", d, 32'h3);
    chk("R7 host irq down", host_irq_o, 0);
  endtask

  task automatic t_ignore;
    logic [31:0] d;
    h_wr(12'h058, 32'hFFFF_FFFF);
    h_rd(12'h058, d); chk("R3 ob msg0 kept", d, 32'h1234);
    h_rd(12'h030, d); chk("R3 no ob status", d, 0);
    l_wr(12'h050, 32'h0);
    l_rd(12'h050, d); chk("R3 ib msg0 kept", d, 32'hA5A5_0001);
    l_rd(12'h100, d); chk("R3 no ib status", d, 0);
    l_wr(12'h034, 32'h0);
    h_rd(12'h034, d); chk("R3 ob mask kept", d, 32'h2B);
  endtask

  task automatic t_dbell;
    logic [31:0] d;
    l_wr(12'h060, 32'h5);
    l_wr(12'h060, 32'h30);
    h_rd(12'h060, d); chk("R4 ob db or", d, 32'h35);
    h_rd(12'h060, d); chk("R4 ob db cleared", d, 0);
    h_rd(12'h030, d); chk("R5 ob db status", d, 32'h8);
    l_wr(12'h060, 32'h0);
    h_rd(12'h030, d); chk("R5 zero write no status", d, 0);
  endtask

  task automatic t_mc;
    logic [31:0] d;
    h_wr(12'h068, 32'h8000_0000);
    l_rd(12'h100, d); chk("R5 mc only", d, 32'h10);
    l_rd(12'h068, d); chk("R4 ib db", d, 32'h8000_0000);
    h_wr(12'h068, 32'h8000_0001);
    l_rd(12'h100, d); chk("R5 mc and db", d, 32'h18);
    l_rd(12'h068, d);
    l_wr(12'h104, 32'h10);
    l_rd(12'h104, d); chk("R6 ib mask", d, 32'h10);
    h_wr(12'h068, 32'h1);
    chk("R6 db masked irq", loc_irq_o, 0);
    l_rd(12'h100, d); chk("R6 db masked read", d, 0);
    h_wr(12'h068, 32'h8000_0000);
    chk("R7 mc irq", loc_irq_o, 1);
    l_rd(12'h100, d); chk("R5 mc status", d, 32'h10);
    l_rd(12'h068, d); chk("R4 ib db accum", d, 32'h8000_0001);
    l_wr(12'h104, 32'h1FF);
  endtask

  task automatic t_qevents;
    logic [31:0] d;
    @(negedge clk_i);
    ib_postq_nempty_i = 1'b1; ib_postq_ovf_i = 1'b1;
    ob_freeq_ovf_i = 1'b1; ob_postq_nempty_i = 1'b1;
    @(negedge clk_i);
    ib_postq_nempty_i = 1'b0; ib_postq_ovf_i = 1'b0;
    ob_freeq_ovf_i = 1'b0; ob_postq_nempty_i = 1'b0;
    l_rd(12'h100, d); chk("R8 ib queue bits", d, 32'h1A0);
    h_rd(12'h030, d); chk("R8 ob queue bit", d, 32'h20);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk_i);
    loc_addr_i = 12'h100; loc_re_i = 1'b1;
    host_addr_i = 12'h054; host_wdata_i = 32'h7; host_we_i = 1'b1;
    @(negedge clk_i); loc_re_i = 1'b0; host_we_i = 1'b0;
    chk("R9 read old status", loc_rdata_o, 0);
    l_rd(12'h100, d); chk("R9 status kept", d, 32'h2);
    @(negedge clk_i);
    loc_addr_i = 12'h068; loc_re_i = 1'b1;
    host_addr_i = 12'h068; host_wdata_i = 32'h4; host_we_i = 1'b1;
    @(negedge clk_i); loc_re_i = 1'b0; host_we_i = 1'b0;
    chk("R9 read old db", loc_rdata_o, 0);
    l_rd(12'h068, d); chk("R9 db kept", d, 32'h4);
    l_rd(12'h100, d); chk("R9 db status", d, 32'h8);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    h_rd(12'h058, d);
    h_rd(12'h010, d); chk("R10 host unmapped", d, 0);
    @(negedge clk_i);
    chk("R10 host hold", host_rdata_o, 0);
    l_rd(12'h054, d);
    @(negedge clk_i);
    chk("R10 loc hold", loc_rdata_o, 32'h7);
    l_rd(12'h030, d); chk("R10 local no ob stat", d, 0);
    h_rd(12'h068, d); chk("R10 host no ib db", d, 0);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_msg;
    t_ignore;
    t_dbell;
    t_mc;
    t_qevents;
    t_set_wins;
    t_unmapped;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule